// File: doc/BRIEF.md
# Pre-trigger acquisition sequencer

This block runs a multi-channel scan acquisition that keeps data from before the event of interest. After a qualified edge on the start trigger it starts paced scans of a fixed channel list. Every conversion is written into a circular sample buffer, and the oldest entries are overwritten while the run waits for the stop trigger. The write pointer wraps modulo the buffer depth.

A qualified stop trigger marks the reference point and raises a one-cycle interrupt. It also loads a post-trigger scan count. That count goes down by one for every scan that completes afterwards, and the run halts when it reaches zero. The host then reads the buffer from the reported oldest index. Both triggers pass through a glitch filter with a selectable active edge. A pacer gate can hold off new scans without disturbing the run's state.

Top module: `pretrig_seq`

## Requirements
- R1: After reset `acq_active` is low and no sample is written. A qualified start edge raises `acq_active` one cycle after it is recognised. Scan and conversion ticks before that write nothing.
- R2: A trigger input must hold its new level for `MIN_PW` consecutive clocks to count; shorter pulses are ignored. The polarity select chooses the active edge, with 0 meaning rising and 1 meaning falling.
- R3: While active and not mid-scan, a `scan_tick` with `pacer_gate` high starts a scan and drives `sos_strobe` high for exactly `SOS_W` cycles, starting the cycle after the tick.
- R4: Each `conv_tick` inside a scan produces a one-cycle `sample_we`, with `sample_addr` set to the write pointer and `sample_data` set to `sample_in`. A scan ends after `NUM_CH` conversions. A `conv_tick` outside a scan writes nothing.
- R5: The write pointer wraps from `DEPTH-1` to 0, and `ring_full` is set at the first wrap. `oldest_idx` equals the pointer when `ring_full` is set and 0 otherwise. A start clears both.
- R6: A stop edge is accepted only in the pre-trigger phase, and acceptance pulses `stop_irq` for one cycle. Stop edges before the start or after acceptance are ignored.
- R7: After acceptance, `post_scans` completed scans are counted, including a scan already in progress. `acq_active` falls the cycle after the last one completes. A count of zero halts the run at acceptance.
- R8: With `pacer_gate` low no new scan starts. A scan in progress finishes, and the pointer and counters are kept.
- R9: After a halt the pointer, `ring_full` and `oldest_idx` hold, and ticks write nothing until the next start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_trig | input | 1 | Raw start trigger line |
| stop_trig | input | 1 | Raw stop trigger line |
| start_falling | input | 1 | 1 selects the falling edge of the start line |
| stop_falling | input | 1 | 1 selects the falling edge of the stop line |
| post_scans | input | POST_W | Scans to collect after the stop trigger |
| pacer_gate | input | 1 | High allows new scans |
| scan_tick | input | 1 | Scan pacing tick |
| conv_tick | input | 1 | Conversion pacing tick |
| sample_in | input | DATA_W | Converted sample |
| sample_we | output | 1 | Buffer write strobe, one per conversion |
| sample_addr | output | AW | Buffer write address |
| sample_data | output | DATA_W | Buffer write data |
| sos_strobe | output | 1 | Start-of-scan one-shot |
| acq_active | output | 1 | Acquisition sequence running |
| stop_irq | output | 1 | One-cycle stop interrupt |
| ring_full | output | 1 | Buffer has wrapped at least once |
| oldest_idx | output | AW | Index of the oldest valid sample |

## Verification
The bench builds the block with a buffer depth of 8, three channels per scan, a 3-cycle trigger filter and a 2-cycle start-of-scan strobe. The small depth means a few pre-trigger scans already wrap the pointer, so the full flag and the oldest-index switch can be checked directly. The short filter keeps rejected and accepted pulses only one clock apart. Both edge polarities, a zero post count and a stop that arrives in the middle of a scan are all driven within a few hundred cycles.

// File: rtl/pretrig_pkg.sv
`timescale 1ns/1ps
package pretrig_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_PRE, PH_POST} phase_t;

  function automatic int unsigned ring_next(input int unsigned p, input int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  function automatic int unsigned ring_oldest(input int unsigned p, input logic wrapped);
    return wrapped ? p : 0;
  endfunction
endpackage

// File: rtl/pts_trig_qual.sv
`timescale 1ns/1ps
module pts_trig_qual #(
  parameter int MIN_PW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic falling,
  output logic evt
);
  localparam int CW = (MIN_PW > 1) ? $clog2(MIN_PW) : 1;

  logic          filt;
  logic [CW-1:0] run;
  logic          settle;

  // new level has been held long enough to replace the filtered level
  assign settle = (raw != filt) && (run == CW'(MIN_PW - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filt <= 1'b0;
      run  <= '0;
      evt  <= 1'b0;
    end else begin
      evt <= settle && (raw != falling);
      if (raw == filt) begin
        run <= '0;
      end else if (settle) begin
        filt <= raw;
        run  <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end
  end

  p_evt_on_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> (filt != $past(filt)));
endmodule

// File: rtl/pts_ring_ptr.sv
`timescale 1ns/1ps
module pts_ring_ptr
  import pretrig_pkg::*;
#(
  parameter int DEPTH = 8192,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          adv,
  output logic [AW-1:0] ptr,
  output logic          full,
  output logic [AW-1:0] oldest
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      ptr  <= '0;
      full <= 1'b0;
    end else if (adv) begin
      ptr <= AW'(ring_next(32'(ptr), DEPTH));
      if (ptr == AW'(DEPTH - 1)) full <= 1'b1;
    end
  end

  assign oldest = AW'(ring_oldest(32'(ptr), full));

  p_wrap_sets_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clear && ptr == AW'(DEPTH - 1)) |=> (ptr == '0 && full));
endmodule

// File: rtl/pts_post_cnt.sv
`timescale 1ns/1ps
module pts_post_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec) cnt <= cnt - 1'b1;
  end

  assign last = (cnt == W'(1));

  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |-> (cnt != '0));
endmodule

// File: rtl/pretrig_seq.sv
`timescale 1ns/1ps
module pretrig_seq
  import pretrig_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DEPTH  = 8192,
  parameter int DATA_W = 16,
  parameter int POST_W = 16,
  parameter int MIN_PW = 2,
  parameter int SOS_W  = 3,
  localparam int AW    = $clog2(DEPTH),
  localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int SW    = $clog2(SOS_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_trig,
  input  logic              stop_trig,
  input  logic              start_falling,
  input  logic              stop_falling,
  input  logic [POST_W-1:0] post_scans,
  input  logic              pacer_gate,
  input  logic              scan_tick,
  input  logic              conv_tick,
  input  logic [DATA_W-1:0] sample_in,
  output logic              sample_we,
  output logic [AW-1:0]     sample_addr,
  output logic [DATA_W-1:0] sample_data,
  output logic              sos_strobe,
  output logic              acq_active,
  output logic              stop_irq,
  output logic              ring_full,
  output logic [AW-1:0]     oldest_idx
);
  phase_t         phase;
  logic           in_scan;
  logic [CHW-1:0] conv_idx;
  logic [SW-1:0]  sos_cnt;
  logic [AW-1:0]  wr_ptr;
  logic           cnt_last;

  // named internal events
  logic [1:0] trig_raw, trig_fall, trig_evt;
  logic start_evt, stop_evt, start_take, stop_take;
  logic scan_begin, conv_fire, scan_done, post_dec, run_end;

  assign trig_raw  = {stop_trig, start_trig};
  assign trig_fall = {stop_falling, start_falling};

  for (genvar g = 0; g < 2; g++) begin : g_qual
    pts_trig_qual #(.MIN_PW(MIN_PW)) u_qual (
      .clk(clk), .rst_n(rst_n), .raw(trig_raw[g]),
      .falling(trig_fall[g]), .evt(trig_evt[g])
    );
  end

  assign start_evt  = trig_evt[0];
  assign stop_evt   = trig_evt[1];
  assign acq_active = (phase != PH_IDLE);
  assign start_take = start_evt && (phase == PH_IDLE);
  assign stop_take  = stop_evt && (phase == PH_PRE);
  assign scan_begin = acq_active && scan_tick && pacer_gate && !in_scan;
  assign conv_fire  = in_scan && conv_tick;
  assign scan_done  = conv_fire && (conv_idx == CHW'(NUM_CH - 1));
  assign post_dec   = (phase == PH_POST) && scan_done;
  assign run_end    = (stop_take && post_scans == '0) || (post_dec && cnt_last);

  pts_ring_ptr #(.DEPTH(DEPTH), .AW(AW)) u_ring (
    .clk(clk), .rst_n(rst_n), .clear(start_take), .adv(conv_fire),
    .ptr(wr_ptr), .full(ring_full), .oldest(oldest_idx)
  );

  pts_post_cnt #(.W(POST_W)) u_post (
    .clk(clk), .rst_n(rst_n), .load(stop_take), .load_val(post_scans),
    .dec(post_dec), .last(cnt_last)
  );

  // phase sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      stop_irq <= 1'b0;
    end else begin
      stop_irq <= stop_take;
      if (run_end)         phase <= PH_IDLE;
      else if (stop_take)  phase <= PH_POST;
      else if (start_take) phase <= PH_PRE;
    end
  end

  // scan and conversion tracking
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_scan     <= 1'b0;
      conv_idx    <= '0;
      sos_cnt     <= '0;
      sample_we   <= 1'b0;
      sample_addr <= '0;
      sample_data <= '0;
    end else begin
      sample_we <= conv_fire;
      if (conv_fire) begin
        sample_addr <= wr_ptr;
        sample_data <= sample_in;
      end
      if (scan_begin)          sos_cnt <= SW'(SOS_W);
      else if (sos_cnt != '0)  sos_cnt <= sos_cnt - 1'b1;
      if (run_end || scan_done) begin
        in_scan  <= 1'b0;
        conv_idx <= '0;
      end else if (scan_begin) begin
        in_scan  <= 1'b1;
        conv_idx <= '0;
      end else if (conv_fire) begin
        conv_idx <= conv_idx + 1'b1;
      end
    end
  end

  assign sos_strobe = (sos_cnt != '0);

  p_active_needs_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acq_active) |-> $past(start_evt));
  p_sos_on_begin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    scan_begin |=> sos_strobe);
  p_write_only_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_we |-> $past(acq_active));
  p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_irq |=> !stop_irq);
  p_halt_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (post_dec && cnt_last) |=> !acq_active);
  p_gate_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pacer_gate && !in_scan) |=> !in_scan);
endmodule

// File: tb/test_pretrig_seq.sv
`timescale 1ns/1ps
module test_pretrig_seq;
  localparam int NC = 3, DEP = 8, DW = 12, PW = 4, MPW = 3, SOSW = 2;
  localparam int AW = $clog2(DEP);

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_trig = 0, stop_trig = 0, start_falling = 0, stop_falling = 0;
  logic [PW-1:0] post_scans = '0;
  logic pacer_gate = 1, scan_tick = 0, conv_tick = 0;
  logic [DW-1:0] sample_in = '0;
  logic sample_we, sos_strobe, acq_active, stop_irq, ring_full;
  logic [AW-1:0] sample_addr, oldest_idx;
  logic [DW-1:0] sample_data;

  pretrig_seq #(.NUM_CH(NC), .DEPTH(DEP), .DATA_W(DW), .POST_W(PW),
                .MIN_PW(MPW), .SOS_W(SOSW)) i_pretrig_seq (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0, irq_seen = 0, irq_exp = 0;
  int qa[$], qd[$];
  bit done = 0;
  // reference model state
  bit m_active = 0, m_post_ph = 0, m_inscan = 0, m_wrapped = 0;
  int m_ptr = 0, m_ci = 0, m_post = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected writes, counts interrupt cycles
  always @(negedge clk) if (rst_n) begin
    if (stop_irq) irq_seen++;
    if (sample_we) begin
      if (qa.size() == 0) chk("R4 unexpected write", 1, 0);
      else begin
        chk("R4 write address", int'(sample_addr), qa.pop_front());
        chk("R4 write data", int'(sample_data), qd.pop_front());
      end
    end
  end

  task automatic trig(input bit is_stop, input int n);
    logic idle_lvl;
    idle_lvl = is_stop ? stop_falling : start_falling;
    @(negedge clk);
    if (is_stop) stop_trig = ~idle_lvl; else start_trig = ~idle_lvl;
    repeat (n) @(negedge clk);
    if (is_stop) stop_trig = idle_lvl; else start_trig = idle_lvl;
    repeat (5) @(negedge clk);
    if (n >= MPW) begin
      if (!is_stop && !m_active) begin
        m_active = 1; m_post_ph = 0; m_ptr = 0; m_wrapped = 0; m_inscan = 0;
      end else if (is_stop && m_active && !m_post_ph) begin
        irq_exp++;
        if (post_scans == 0) begin m_active = 0; m_inscan = 0; end
        else begin m_post_ph = 1; m_post = int'(post_scans); end
      end
    end
  endtask

  task automatic scan_begin();
    bit started;
    @(negedge clk);
    scan_tick = 1;
    started = m_active && pacer_gate && !m_inscan;
    @(negedge clk);
    scan_tick = 0;
    chk("R3 sos strobe after tick", int'(sos_strobe), int'(started));
    if (started) begin m_inscan = 1; m_ci = 0; end
  endtask

  task automatic conv(input int data);
    @(negedge clk);
    conv_tick = 1;
    sample_in = DW'(data);
    if (m_inscan) begin
      qa.push_back(m_ptr); qd.push_back(data);
      m_ptr = (m_ptr + 1) % DEP;
      if (m_ptr == 0) m_wrapped = 1;
      m_ci++;
      if (m_ci == NC) begin
        m_inscan = 0;
        if (m_post_ph) begin
          m_post--;
          if (m_post == 0) m_active = 0;
        end
      end
    end
    @(negedge clk);
    conv_tick = 0;
  endtask

  task automatic full_scan(input int base);
    scan_begin();
    for (int i = 0; i < NC; i++) conv(base + i);
  endtask

  task automatic chk_ring(input string tag);
    chk({tag, " ring_full"}, int'(ring_full), int'(m_wrapped));
    chk({tag, " oldest_idx"}, int'(oldest_idx), m_wrapped ? m_ptr : 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset active", int'(acq_active), 0);
    chk("R1 reset irq", int'(stop_irq), 0);
    chk("R1 reset we", int'(sample_we), 0);
    chk_ring("R5 reset");

    full_scan(16'h010);                         // R1: no writes while idle
    chk("R1 idle after ticks", int'(acq_active), 0);
    trig(1, 3);                                 // R6: stop before start
    chk("R6 early stop irq", irq_seen, irq_exp);
    trig(0, 2);                                 // R2: short pulse rejected
    chk("R2 short start ignored", int'(acq_active), 0);
    trig(0, 3);
    chk("R1 start accepted", int'(acq_active), 1);
    conv(16'h0AA);                              // R4: conv outside scan

    full_scan(16'h100);
    full_scan(16'h110);
    chk_ring("R5 before wrap");
    scan_begin();                               // R3: strobe width
    @(negedge clk); chk("R3 sos second cycle", int'(sos_strobe), 1);
    @(negedge clk); chk("R3 sos ends", int'(sos_strobe), 0);
    for (int i = 0; i < NC; i++) conv(16'h120 + i);
    full_scan(16'h130);
    chk_ring("R5 after wrap");

    scan_begin();                               // R8: gate drop mid-scan
    pacer_gate = 0;
    for (int i = 0; i < NC; i++) conv(16'h140 + i);
    full_scan(16'h150);                         // R8: gated off
    chk_ring("R8 gated");
    pacer_gate = 1;

    post_scans = 2;
    trig(1, 3);
    chk("R6 stop irq", irq_seen, irq_exp);
    trig(1, 3);                                 // R6: second stop ignored
    chk("R6 repeated stop", irq_seen, irq_exp);
    full_scan(16'h200);
    chk("R7 active after one post scan", int'(acq_active), 1);
    full_scan(16'h210);
    chk("R7 halted after post scans", int'(acq_active), 0);
    full_scan(16'h220);                         // R9: ignored after halt
    chk_ring("R9 held");
    trig(1, 3);
    chk("R9 stop after halt", irq_seen, irq_exp);

    start_falling = 1; stop_falling = 1;        // R2: falling polarity
    @(negedge clk); start_trig = 1; stop_trig = 1;
    repeat (6) @(negedge clk);
    chk("R2 idle-high not a trigger", int'(acq_active), 0);
    trig(0, 3);
    chk("R2 falling start", int'(acq_active), 1);
    chk_ring("R5 cleared by start");
    full_scan(16'h300);
    post_scans = 0;
    trig(1, 3);
    chk("R7 zero count halts", int'(acq_active), 0);
    chk("R6 falling stop irq", irq_seen, irq_exp);

    trig(0, 3);
    post_scans = 1;
    scan_begin();
    conv(16'h400);
    trig(1, 3);
    chk("R7 scan in flight keeps run", int'(acq_active), 1);
    conv(16'h401);
    conv(16'h402);
    chk("R7 in-flight scan counted", int'(acq_active), 0);
    chk_ring("R9 final");

    repeat (4) @(negedge clk);
    chk("R4 all writes seen", qa.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule